// File: doc/BRIEF.md
# Run-time programmable pattern matcher

This block searches a byte stream for a pattern that is held in a small instruction memory. The memory is written at run time, so changing the pattern needs no change to the hardware. Each instruction word describes one pattern step. A step can be a literal byte, a byte range, a wildcard, a greedy zero-or-more repeat or a greedy one-or-more repeat of a range, or the pattern terminator. A sequencer walks the steps as bytes arrive on a valid/ready stream. Every step is tested by the same three byte comparators: one for equality, one for greater-or-equal and one for less-or-equal.

When the sequencer is not partway through a match, it takes one byte every clock. Some steps need the same byte to be tested a second time: leaving a repeat step, or retrying after a mismatch. Reaching the terminator also costs a cycle. In each of these cases the sequencer holds `ch_ready_o` low for one cycle, so no byte is lost. A completed match raises a one-cycle pulse that carries the stream offset of the last byte of the match. The sequencer then starts again from the first step. It never backtracks into earlier bytes.

Top module: `regex_engine`

## Requirements
- R1: An instruction word is 23 bits wide, laid out as {op[22:20], lo[19:12], hi[11:4], cnt[3:0]}. The opcodes are LIT=0, RANGE=1, ANY=2, STAR=3, PLUS=4 and END=5; the codes 6 and 7 behave as END. Reset fills every memory word with END.
- R2: A write to the instruction memory is accepted only while the engine is idle. A write requested at any other time leaves the memory unchanged and sets `load_err_o` high for exactly the one cycle after the request. `ch_ready_o` is low in every cycle in which `load_en_i` is high.
- R3: LIT matches a byte equal to lo. RANGE matches a byte with lo <= byte <= hi. ANY matches any byte. Each of these three steps needs cnt consecutive matching bytes before it advances, and a cnt of 0 counts as 1.
- R4: STAR consumes every following byte that lies in lo..hi, which may be none. The first byte outside the range is tested again against the next step and is not counted twice.
- R5: PLUS behaves like STAR, but it needs at least one byte in range. A first byte outside the range is a mismatch.
- R6: On a mismatch after some progress, the pointer returns to the first step and the same byte is tested again in the next cycle, with `ch_ready_o` low in that cycle. A mismatch at the first step with no progress drops the byte.
- R7: Reaching END at an address other than 0 costs one cycle with `ch_ready_o` low. In the following cycle `match_o` is high for one cycle. `match_off_o` then holds the zero-based offset, counted over accepted bytes since reset, of the last byte the match consumed. Matching then restarts at the first step.
- R8: If address 0 holds END (an empty pattern), the engine never signals a match and accepts one byte every cycle.
- R9: With no partial match in progress and no load requested, `ch_ready_o` is high and one byte is accepted on every clock cycle.
- R10: After reset, `ch_ready_o` is 1, and `match_o`, `load_err_o` and `match_off_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Instruction write request |
| load_addr_i | input | $clog2(DEPTH) | Instruction address to write |
| load_instr_i | input | 23 | Instruction word to write |
| load_err_o | output | 1 | Pulse: a write was refused because matching was in progress |
| ch_valid_i | input | 1 | Input byte valid |
| ch_data_i | input | 8 | Input byte |
| ch_ready_o | output | 1 | Engine accepts a byte this cycle |
| match_o | output | 1 | One-cycle match pulse |
| match_off_o | output | OFF_W | Offset of the last byte of the reported match |

## Verification
The assertions check, on every cycle, properties that hold regardless of the pattern:
- A refused-write flag always follows a write request.
- A match pulse never lasts two cycles, and it coincides with the pointer back at the first step.
- A reported offset always lies behind the byte counter.
- The byte counter advances by exactly one on each accepted byte.

Only the bench scenarios can show that the right bytes match. These scenarios cover how steps advance, and how repeat steps hand a byte on to the next step. They also show that a refused write really left the pattern intact, and that stall cycles fall exactly where the rules above put them.

// File: rtl/regex_pkg.sv
package regex_pkg;
  localparam int CH_W  = 8;
  localparam int CNT_W = 4;

  localparam logic [2:0] OP_LIT   = 3'd0;
  localparam logic [2:0] OP_RANGE = 3'd1;
  localparam logic [2:0] OP_ANY   = 3'd2;
  localparam logic [2:0] OP_STAR  = 3'd3;
  localparam logic [2:0] OP_PLUS  = 3'd4;
  localparam logic [2:0] OP_END   = 3'd5;

  typedef struct packed {
    logic [2:0]       op;
    logic [CH_W-1:0]  lo;
    logic [CH_W-1:0]  hi;
    logic [CNT_W-1:0] cnt;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  localparam int CMP_EQ = 0;
  localparam int CMP_GE = 1;
  localparam int CMP_LE = 2;
  localparam int N_CMP  = 3;
endpackage

// File: rtl/regex_cmp.sv
module regex_cmp #(
  parameter int KIND = 0,
  parameter int W    = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         hit_o
);
  generate
    if (KIND == 0) begin : g_eq
      assign hit_o = (a_i == b_i);
    end else if (KIND == 1) begin : g_ge
      assign hit_o = (a_i >= b_i);
    end else begin : g_le
      assign hit_o = (a_i <= b_i);
    end
  endgenerate
endmodule

// File: rtl/regex_imem.sv
module regex_imem
  import regex_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_req_i,
  input  logic [AW-1:0] waddr_i,
  input  instr_t        wdata_i,
  input  logic          idle_i,
  input  logic [AW-1:0] raddr_i,
  output instr_t        rdata_o,
  output logic          err_o
);
  localparam instr_t END_WORD = '{op: OP_END, lo: '0, hi: '0, cnt: '0};

  instr_t mem_q [DEPTH];
  logic   err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= END_WORD;
      err_q <= 1'b0;
    end else begin
      if (we_req_i && idle_i) mem_q[waddr_i] <= wdata_i;
      err_q <= we_req_i && !idle_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
  assign err_o   = err_q;

  // R2
  err_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(we_req_i));
endmodule

// File: rtl/regex_seq.sv
module regex_seq
  import regex_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OFF_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ch_valid_i,
  input  logic [CH_W-1:0]  ch_data_i,
  input  logic             load_req_i,
  input  logic [2:0]       op_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             eq_i,
  input  logic             ge_i,
  input  logic             le_i,
  output logic [CH_W-1:0]  cur_ch_o,
  output logic [AW-1:0]    ip_o,
  output logic             idle_o,
  output logic             ch_ready_o,
  output logic             match_o,
  output logic [OFF_W-1:0] match_off_o
);
  logic [AW-1:0]    ip_q, ip_d;
  logic [CNT_W-1:0] rep_q, rep_d;
  logic             seen_q, seen_d;
  logic             hold_q, keep;
  logic [CH_W-1:0]  held_ch_q;
  logic [OFF_W-1:0] held_off_q, off_q, last_off_q, moff_q, cur_off;
  logic             match_q, match_d;
  logic             is_end, end_now, accept, eval, hit, last_rep, progress, miss, take;
  logic [CNT_W-1:0] need;

  assign is_end     = (op_i >= OP_END);
  assign end_now    = is_end && (ip_q != '0);
  assign ch_ready_o = !hold_q && !end_now && !load_req_i;
  assign accept     = ch_valid_i && ch_ready_o;
  assign eval       = !end_now && (hold_q || accept);
  assign cur_ch_o   = hold_q ? held_ch_q : ch_data_i;
  assign cur_off    = hold_q ? held_off_q : off_q;
  assign need       = (cnt_i == '0) ? CNT_W'(1) : cnt_i;
  assign last_rep   = ({1'b0, rep_q} + 1'b1) >= {1'b0, need};
  assign progress   = (ip_q != '0) || (rep_q != '0) || seen_q;

  always_comb begin
    unique case (op_i)
      OP_LIT:                    hit = eq_i;
      OP_RANGE, OP_STAR, OP_PLUS: hit = ge_i && le_i;
      OP_ANY:                    hit = 1'b1;
      default:                   hit = 1'b0;
    endcase
  end

  always_comb begin
    ip_d    = ip_q;
    rep_d   = rep_q;
    seen_d  = seen_q;
    keep    = 1'b0;
    take    = 1'b0;
    miss    = 1'b0;
    match_d = 1'b0;
    if (end_now) begin
      match_d = 1'b1;
      ip_d    = '0;
      rep_d   = '0;
      seen_d  = 1'b0;
      keep    = hold_q;
    end else if (eval) begin
      unique case (op_i)
        OP_LIT, OP_RANGE, OP_ANY: begin
          if (hit) begin
            take = 1'b1;
            if (last_rep) begin
              ip_d  = ip_q + 1'b1;
              rep_d = '0;
            end else begin
              rep_d = rep_q + 1'b1;
            end
          end else begin
            miss = 1'b1;
          end
        end
        OP_STAR: begin
          if (hit) begin
            take   = 1'b1;
            seen_d = 1'b1;
          end else begin
            ip_d   = ip_q + 1'b1;
            seen_d = 1'b0;
            keep   = 1'b1;
          end
        end
        OP_PLUS: begin
          if (hit) begin
            take   = 1'b1;
            seen_d = 1'b1;
          end else if (seen_q) begin
            ip_d   = ip_q + 1'b1;
            seen_d = 1'b0;
            keep   = 1'b1;
          end else begin
            miss = 1'b1;
          end
        end
        default: ;  // empty pattern: byte dropped
      endcase
      if (miss && progress) begin
        ip_d   = '0;
        rep_d  = '0;
        seen_d = 1'b0;
        keep   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_q       <= '0;
      rep_q      <= '0;
      seen_q     <= 1'b0;
      hold_q     <= 1'b0;
      held_ch_q  <= '0;
      held_off_q <= '0;
      off_q      <= '0;
      last_off_q <= '0;
      moff_q     <= '0;
      match_q    <= 1'b0;
    end else begin
      ip_q    <= ip_d;
      rep_q   <= rep_d;
      seen_q  <= seen_d;
      hold_q  <= keep;
      match_q <= match_d;
      if (accept) off_q <= off_q + 1'b1;
      if (keep && !hold_q) begin
        held_ch_q  <= ch_data_i;
        held_off_q <= off_q;
      end
      if (take) last_off_q <= cur_off;
      if (match_d) moff_q <= last_off_q;
    end
  end

  assign ip_o        = ip_q;
  assign idle_o      = !progress && !hold_q;
  assign match_o     = match_q;
  assign match_off_o = moff_q;

  // R7
  match_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);
  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (ip_q == '0));
  // R7
  off_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (match_off_o < off_q));
  // R9
  off_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (off_q == $past(off_q) + 1'b1));
endmodule

// File: rtl/regex_engine.sv
module regex_engine
  import regex_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OFF_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic [AW-1:0]      load_addr_i,
  input  logic [INSTR_W-1:0] load_instr_i,
  output logic               load_err_o,
  input  logic               ch_valid_i,
  input  logic [CH_W-1:0]    ch_data_i,
  output logic               ch_ready_o,
  output logic               match_o,
  output logic [OFF_W-1:0]   match_off_o
);
  instr_t          cur_instr;
  logic [AW-1:0]   ip;
  logic            idle;
  logic [CH_W-1:0] cur_ch;
  logic [N_CMP-1:0] cmp_hit;

  regex_imem #(.DEPTH(DEPTH)) u_imem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_req_i (load_en_i),
    .waddr_i  (load_addr_i),
    .wdata_i  (instr_t'(load_instr_i)),
    .idle_i   (idle),
    .raddr_i  (ip),
    .rdata_o  (cur_instr),
    .err_o    (load_err_o)
  );

  // shared comparator bank: every step reuses these three
  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    regex_cmp #(.KIND(g), .W(CH_W)) u_cmp (
      .a_i   (cur_ch),
      .b_i   ((g == CMP_LE) ? cur_instr.hi : cur_instr.lo),
      .hit_o (cmp_hit[g])
    );
  end

  regex_seq #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ch_valid_i  (ch_valid_i),
    .ch_data_i   (ch_data_i),
    .load_req_i  (load_en_i),
    .op_i        (cur_instr.op),
    .cnt_i       (cur_instr.cnt),
    .eq_i        (cmp_hit[CMP_EQ]),
    .ge_i        (cmp_hit[CMP_GE]),
    .le_i        (cmp_hit[CMP_LE]),
    .cur_ch_o    (cur_ch),
    .ip_o        (ip),
    .idle_o      (idle),
    .ch_ready_o  (ch_ready_o),
    .match_o     (match_o),
    .match_off_o (match_off_o)
  );
endmodule

// File: tb/regex_engine_tb.sv
module regex_engine_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0][22:0] pat;
    logic [63:0]      str;
    logic [3:0]       len;
    logic [1:0]       nexp;
    logic [1:0][15:0] exp;
    logic [15:0]      tag;
  } vec_t;

  function automatic logic [22:0] mk(logic [2:0] op, logic [7:0] lo, logic [7:0] hi, logic [3:0] c);
    return {op, lo, hi, c};
  endfunction

  localparam logic [22:0] E = {3'd5, 20'd0};

  localparam vec_t VECS [8] = '{
    '{{mk(0,"a",0,0), mk(0,"b",0,0), E, E}, 64'("xabab"), 4'd5, 2'd2, {16'd2, 16'd4}, "R7"},
    '{{mk(0,"a",0,0), mk(0,"b",0,0), E, E}, 64'("aab"), 4'd3, 2'd1, {16'd2, 16'd0}, "R6"},
    '{{mk(1,"0","9",3), E, E, E}, 64'("12a345"), 4'd6, 2'd1, {16'd5, 16'd0}, "R3"},
    '{{mk(0,"a",0,0), mk(3,"b","b",0), mk(0,"c",0,0), E}, 64'("abbbc ac"), 4'd8, 2'd2, {16'd4, 16'd7}, "R4"},
    '{{mk(0,"q",0,0), mk(4,"0","9",0), mk(0,";",0,0), E}, 64'("q;q12;"), 4'd6, 2'd1, {16'd5, 16'd0}, "R5"},
    '{{mk(0,"a",0,0), mk(2,0,0,2), mk(0,"z",0,0), E}, 64'("a1za9zz"), 4'd7, 2'd1, {16'd6, 16'd0}, "R3"},
    '{{E, E, E, E}, 64'("aaaa"), 4'd4, 2'd0, {16'd0, 16'd0}, "R8"},
    '{{mk(0,"k",0,0), {3'd7, 20'd0}, E, E}, 64'("kk"), 4'd2, 2'd2, {16'd0, 16'd1}, "R1"}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        load_en = 0;
  logic [2:0]  load_addr = '0;
  logic [22:0] load_instr = '0;
  logic        load_err;
  logic        ch_valid = 0;
  logic [7:0]  ch_data = '0;
  logic        ch_ready;
  logic        match;
  logic [15:0] match_off;

  int checks = 0;
  int errors = 0;
  int ncap = 0;
  logic [15:0] cap [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  regex_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_addr_i(load_addr),
    .load_instr_i(load_instr), .load_err_o(load_err), .ch_valid_i(ch_valid),
    .ch_data_i(ch_data), .ch_ready_o(ch_ready), .match_o(match), .match_off_o(match_off)
  );

  always @(negedge clk) if (rst_n && match) begin
    if (ncap < 4) cap[ncap] = match_off;
    ncap++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ncap = 0;
  endtask

  task automatic load_word(input int addr, input logic [22:0] w);
    load_en = 1; load_addr = 3'(addr); load_instr = w;
    @(posedge clk);
    @(negedge clk);
    load_en = 0;
  endtask

  task automatic send(input logic [7:0] c);
    ch_valid = 1; ch_data = c;
    #1;
    while (!ch_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    ch_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    do_reset();
    check("R10 ready", int'(ch_ready), 1);
    check("R10 match", int'(match), 0);
    check("R10 err", int'(load_err), 0);
    check("R10 off", int'(match_off), 0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      do_reset();
      for (int k = 0; k < 4; k++) load_word(k, VECS[v].pat[3-k]);
      ncap = 0;
      for (int i = 0; i < int'(VECS[v].len); i++)
        send(VECS[v].str[8*(int'(VECS[v].len)-1-i) +: 8]);
      repeat (4) @(negedge clk);
      check($sformatf("%s vec%0d count", VECS[v].tag, v), ncap, int'(VECS[v].nexp));
      for (int m = 0; m < int'(VECS[v].nexp); m++)
        check($sformatf("%s vec%0d off%0d", VECS[v].tag, v, m), int'(cap[m]), int'(VECS[v].exp[1-m]));
    end

    // R2 accepted load while idle, refused load mid-match
    do_reset();
    load_word(0, mk(0, "a", 0, 0));
    check("R2 idle load no err", int'(load_err), 0);
    load_word(1, mk(0, "b", 0, 0));
    send("a");
    load_en = 1; load_addr = 3'd1; load_instr = mk(0, "c", 0, 0);
    #1;
    check("R2 ready low on load", int'(ch_ready), 0);
    @(negedge clk);
    load_en = 0;
    check("R2 err pulse", int'(load_err), 1);
    @(negedge clk);
    check("R2 err one cycle", int'(load_err), 0);
    ncap = 0;
    send("b");
    repeat (3) @(negedge clk);
    check("R2 pattern unchanged", ncap, 1);
    check("R2 match off", int'(cap[0]), 1);

    // R6 retry stall
    do_reset();
    load_word(0, mk(0, "a", 0, 0));
    load_word(1, mk(0, "b", 0, 0));
    send("a");
    send("a");
    check("R6 ready low on retry", int'(ch_ready), 0);
    @(negedge clk);
    check("R6 ready back", int'(ch_ready), 1);

    // R7 END stall and pulse timing
    do_reset();
    load_word(0, mk(0, "a", 0, 0));
    ncap = 0;
    send("a");
    check("R7 stall at END", int'(ch_ready), 0);
    check("R7 no pulse yet", int'(match), 0);
    @(negedge clk);
    check("R7 pulse", int'(match), 1);
    check("R7 off", int'(match_off), 0);
    check("R7 ready after", int'(ch_ready), 1);

    // R9 and R8: one byte per cycle with empty pattern
    do_reset();
    begin
      int acc = 0;
      ch_valid = 1;
      for (int i = 0; i < 10; i++) begin
        ch_data = 8'("a" + i);
        #1;
        if (ch_ready) acc++;
        @(negedge clk);
      end
      ch_valid = 0;
      check("R9 bytes per cycle", acc, 10);
      check("R8 no match", ncap, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule